// File: doc/BRIEF.md
# Palette Lookup Pixel Output Stage

This block turns a stream of one-byte pixels into colour words for an active-matrix panel. Each incoming byte is an index. It addresses three separate 4-bit palettes, one each for red, green and blue, so any 256 of the 4096 possible 12-bit colours can be on screen at once. An optional inversion flips every palette output bit after the lookup. A narrow mode packs the result for a 9-bit panel. Bytes arrive in memory order, and byte n becomes pixel n.

A CPU-side port writes and reads individual palette entries. The pixel path is a fixed two-stage pipeline, and a valid strobe travels with it. A palette write is visible to any pixel that is sampled on the same clock edge as the write or on a later edge.

Top module: `pal_pixel_stage`

## Requirements
- R1: After reset, entry i of every palette holds i[7:4], which gives a grey ramp.
- R2: In wide mode (narrow=0, invert=0), the output is {red[idx], green[idx], blue[idx]}, with red in bits 11:8, green in bits 7:4 and blue in bits 3:0.
- R3: `pan_valid_o` repeats `pix_valid_i` exactly two rising edges later.
- R4: While `pan_valid_o` is low, `pan_data_o` is all zeros, and this includes the state after reset.
- R5: When invert is set with a pixel, each 4-bit palette output is bitwise complemented before it is packed.
- R6: In narrow mode, bits 8:6, 5:3 and 2:0 carry bits 3:1 of the red, green and blue values (after any inversion), and bits 11:9 are zero.
- R7: The colour select is 0 for red, 1 for green and 2 for blue. A write changes the entry seen by a pixel sampled on the same edge or on any later edge. A pixel sampled one edge earlier still sees the old value.
- R8: `cpu_rdata_o` shows, one edge after `cpu_sel_i`/`cpu_addr_i` are sampled, the entry as it was before any write on that edge. Select value 3 reads zero, and a write with that select changes nothing.
- R9: A write to one colour's palette leaves the other two palettes unchanged.
- R10: Back-to-back valid bytes come out back-to-back, in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid_i | input | 1 | Pixel byte valid |
| pix_index_i | input | 8 | Pixel byte (palette index) |
| inv_en_i | input | 1 | Invert palette outputs for this pixel |
| narrow_en_i | input | 1 | Format this pixel for a 9-bit panel |
| cpu_we_i | input | 1 | Palette write strobe |
| cpu_sel_i | input | 2 | Colour select: 0 red, 1 green, 2 blue, 3 none |
| cpu_addr_i | input | 8 | Palette entry index |
| cpu_wdata_i | input | 4 | Write data |
| cpu_rdata_o | output | 4 | Read data, one cycle after address |
| pan_valid_o | output | 1 | Output pixel valid |
| pan_data_o | output | 12 | Packed RGB panel data |

## Verification
Several properties are checked on every cycle: the two-edge valid latency, zero data during idle cycles, zero upper bits in narrow mode, a zero readback for the unused select, and each palette write landing in its entry. The bench alone can show that colours are correct. It does this by comparing every pixel and every readback with a bench-side model of the three palettes, under random writes, random modes and random indices. Directed scenarios cover the reset ramp, write-versus-pixel ordering around a single edge, and the isolation between colours.

// File: rtl/pal_pkg.sv
package pal_pkg;
    typedef enum logic [1:0] {
        SEL_RED  = 2'd0,
        SEL_GRN  = 2'd1,
        SEL_BLU  = 2'd2,
        SEL_NONE = 2'd3
    } col_sel_e;

    localparam int NUM_COL = 3;
endpackage

// File: rtl/pal_bank.sv
module pal_bank #(
    parameter int IDX_W = 8,
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] waddr_i,
    input  logic [COL_W-1:0] wdata_i,
    input  logic [IDX_W-1:0] laddr_i,
    output logic [COL_W-1:0] ldata_o,
    input  logic [IDX_W-1:0] raddr_i,
    output logic [COL_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int SHIFT = IDX_W - COL_W;

    typedef struct packed {
        logic [DEPTH-1:0][COL_W-1:0] ent;
    } bank_s;

    bank_s bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we_i) begin
            bank_d.ent[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                bank_q.ent[i] <= COL_W'(i >> SHIFT);
            end
        end else begin
            bank_q <= bank_d;
        end
    end

    assign ldata_o = bank_q.ent[laddr_i];
    assign rdata_o = bank_q.ent[raddr_i];

    // R7: a written entry holds the written value one edge later
    p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> bank_q.ent[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/pal_fmt.sv
module pal_fmt #(
    parameter int COL_W = 4,
    parameter int NAR_W = 3
) (
    input  logic [COL_W-1:0]   red_i,
    input  logic [COL_W-1:0]   grn_i,
    input  logic [COL_W-1:0]   blu_i,
    input  logic               inv_i,
    input  logic               narrow_i,
    output logic [3*COL_W-1:0] data_o
);
    localparam int OUT_W = 3 * COL_W;
    localparam int PAD_W = OUT_W - 3 * NAR_W;

    logic [COL_W-1:0] r_x, g_x, b_x;

    always_comb begin
        r_x = inv_i ? ~red_i : red_i;
        g_x = inv_i ? ~grn_i : grn_i;
        b_x = inv_i ? ~blu_i : blu_i;
        if (narrow_i) begin
            data_o = {{PAD_W{1'b0}},
                      r_x[COL_W-1 -: NAR_W],
                      g_x[COL_W-1 -: NAR_W],
                      b_x[COL_W-1 -: NAR_W]};
        end else begin
            data_o = {r_x, g_x, b_x};
        end
    end
endmodule

// File: rtl/pal_pixel_stage.sv
module pal_pixel_stage #(
    parameter int IDX_W = 8,
    parameter int COL_W = 4,
    parameter int NAR_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_valid_i,
    input  logic [IDX_W-1:0]   pix_index_i,
    input  logic               inv_en_i,
    input  logic               narrow_en_i,
    input  logic               cpu_we_i,
    input  logic [1:0]         cpu_sel_i,
    input  logic [IDX_W-1:0]   cpu_addr_i,
    input  logic [COL_W-1:0]   cpu_wdata_i,
    output logic [COL_W-1:0]   cpu_rdata_o,
    output logic               pan_valid_o,
    output logic [3*COL_W-1:0] pan_data_o
);
    import pal_pkg::*;

    localparam int OUT_W = 3 * COL_W;
    localparam int NAR_TOP = 3 * NAR_W;

    typedef struct packed {
        logic             s1_valid;
        logic [IDX_W-1:0] s1_idx;
        logic             s1_inv;
        logic             s1_nar;
        logic             out_valid;
        logic [OUT_W-1:0] out_data;
        logic [COL_W-1:0] rdata;
        logic [1:0]       warm;
    } pipe_s;

    pipe_s pipe_d, pipe_q;

    logic [NUM_COL-1:0][COL_W-1:0] look_c;
    logic [NUM_COL-1:0][COL_W-1:0] rd_c;
    logic [OUT_W-1:0]              fmt_data;

    for (genvar c = 0; c < NUM_COL; c++) begin : g_bank
        pal_bank #(.IDX_W(IDX_W), .COL_W(COL_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (cpu_we_i && (cpu_sel_i == 2'(c))),
            .waddr_i (cpu_addr_i),
            .wdata_i (cpu_wdata_i),
            .laddr_i (pipe_q.s1_idx),
            .ldata_o (look_c[c]),
            .raddr_i (cpu_addr_i),
            .rdata_o (rd_c[c])
        );
    end

    pal_fmt #(.COL_W(COL_W), .NAR_W(NAR_W)) u_fmt (
        .red_i    (look_c[SEL_RED]),
        .grn_i    (look_c[SEL_GRN]),
        .blu_i    (look_c[SEL_BLU]),
        .inv_i    (pipe_q.s1_inv),
        .narrow_i (pipe_q.s1_nar),
        .data_o   (fmt_data)
    );

    always_comb begin
        pipe_d           = pipe_q;
        pipe_d.s1_valid  = pix_valid_i;
        pipe_d.s1_idx    = pix_index_i;
        pipe_d.s1_inv    = inv_en_i;
        pipe_d.s1_nar    = narrow_en_i;
        pipe_d.out_valid = pipe_q.s1_valid;
        pipe_d.out_data  = pipe_q.s1_valid ? fmt_data : '0;
        case (col_sel_e'(cpu_sel_i))
            SEL_RED: pipe_d.rdata = rd_c[SEL_RED];
            SEL_GRN: pipe_d.rdata = rd_c[SEL_GRN];
            SEL_BLU: pipe_d.rdata = rd_c[SEL_BLU];
            default: pipe_d.rdata = '0;
        endcase
        if (pipe_q.warm != 2'd2) begin
            pipe_d.warm = pipe_q.warm + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign pan_valid_o = pipe_q.out_valid;
    assign pan_data_o  = pipe_q.out_data;
    assign cpu_rdata_o = pipe_q.rdata;

    // R3: valid strobe trails input valid by exactly two edges
    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.warm == 2'd2) |-> (pan_valid_o == $past(pix_valid_i, 2)));

    // R4: no pixel in stage one means zero data next
    p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_q.s1_valid |=> (pan_data_o == '0));

    // R6: narrow pixels leave the unused top bits clear
    p_narrow_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.s1_valid && pipe_q.s1_nar) |=> (pan_data_o[OUT_W-1:NAR_TOP] == '0));

    // R8: unused select reads zero
    p_none_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel_i == 2'd3) |=> (cpu_rdata_o == '0));
endmodule

// File: tb/sim_pal_pixel_stage.sv
module sim_pal_pixel_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid_i = 1'b0;
    logic [7:0]  pix_index_i = '0;
    logic        inv_en_i = 1'b0;
    logic        narrow_en_i = 1'b0;
    logic        cpu_we_i = 1'b0;
    logic [1:0]  cpu_sel_i = '0;
    logic [7:0]  cpu_addr_i = '0;
    logic [3:0]  cpu_wdata_i = '0;
    logic [3:0]  cpu_rdata_o;
    logic        pan_valid_o;
    logic [11:0] pan_data_o;

    int errors = 0;
    int checks = 0;

    logic [3:0] mdl [3][256];
    logic        e1v, e2v;
    logic [11:0] e1d, e2d;
    string       e1t, e2t;
    logic        rchk;
    logic [3:0]  rexp;
    string       tag_px;
    string       tag_rd;

    always #2.5 clk = ~clk;

    pal_pixel_stage u0 (
        .clk(clk), .rst_n(rst_n), .pix_valid_i(pix_valid_i), .pix_index_i(pix_index_i),
        .inv_en_i(inv_en_i), .narrow_en_i(narrow_en_i), .cpu_we_i(cpu_we_i),
        .cpu_sel_i(cpu_sel_i), .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i),
        .cpu_rdata_o(cpu_rdata_o), .pan_valid_o(pan_valid_o), .pan_data_o(pan_data_o)
    );

    function automatic logic [11:0] expect_px(logic [7:0] idx, logic inv, logic nar);
        logic [3:0] r, g, b;
        r = mdl[0][idx]; g = mdl[1][idx]; b = mdl[2][idx];
        if (inv) begin r = ~r; g = ~g; b = ~b; end
        if (nar) return {3'b000, r[3:1], g[3:1], b[3:1]};
        return {r, g, b};
    endfunction

    task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(logic pv, logic [7:0] idx, logic inv, logic nar,
                        logic we, logic [1:0] sel, logic [7:0] addr, logic [3:0] wd);
        @(negedge clk);
        chk("R3", 12'(pan_valid_o), 12'(e2v));
        if (e2v) chk(e2t, pan_data_o, e2d);
        else     chk("R4", pan_data_o, 12'h000);
        if (rchk) chk(tag_rd, 12'(cpu_rdata_o), 12'(rexp));
        rexp = (sel == 2'd3) ? 4'h0 : mdl[sel][addr];
        rchk = 1'b1;
        if (we && sel != 2'd3) mdl[sel][addr] = wd;
        e2v = e1v; e2d = e1d; e2t = e1t;
        e1v = pv;
        e1d = pv ? expect_px(idx, inv, nar) : 12'h000;
        if (tag_px != "") e1t = tag_px;
        else e1t = nar ? "R6" : (inv ? "R5" : "R2");
        pix_valid_i = pv; pix_index_i = idx; inv_en_i = inv; narrow_en_i = nar;
        cpu_we_i = we; cpu_sel_i = sel; cpu_addr_i = addr; cpu_wdata_i = wd;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 8'h0, 0, 0, 0, 2'd3, 8'h0, 4'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 3; c++)
            for (int i = 0; i < 256; i++) mdl[c][i] = 4'(i >> 4);
        e1v = 0; e2v = 0; e1d = 0; e2d = 0; e1t = "R4"; e2t = "R4";
        rchk = 0; rexp = 0; tag_px = ""; tag_rd = "R8";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset ramp readback of every entry; R10: ordered back-to-back stream
        tag_rd = "R1"; tag_px = "R10";
        for (int c = 0; c < 3; c++)
            for (int i = 0; i < 256; i++)
                step(1, 8'(i), 0, 0, 0, 2'(c), 8'(i), 4'h0);
        idle(3);

        // R7: write ordering around one edge
        tag_rd = "R8"; tag_px = "R7";
        step(1, 8'h40, 0, 0, 0, 2'd3, 8'h0, 4'h0);
        step(1, 8'h40, 0, 0, 1, 2'd2, 8'h40, 4'hA);
        step(1, 8'h40, 0, 0, 0, 2'd3, 8'h0, 4'h0);
        idle(3);

        // R9: other colours unchanged after a red write
        tag_rd = "R9";
        step(0, 8'h0, 0, 0, 1, 2'd0, 8'h55, 4'h9);
        step(0, 8'h0, 0, 0, 0, 2'd1, 8'h55, 4'h0);
        step(0, 8'h0, 0, 0, 0, 2'd2, 8'h55, 4'h0);
        step(0, 8'h0, 0, 0, 0, 2'd0, 8'h55, 4'h0);
        // R8: write with unused select has no effect
        tag_rd = "R8";
        step(0, 8'h0, 0, 0, 1, 2'd3, 8'h55, 4'h3);
        step(0, 8'h0, 0, 0, 0, 2'd0, 8'h55, 4'h0);
        step(0, 8'h0, 0, 0, 0, 2'd1, 8'h55, 4'h0);
        step(1, 8'h55, 1, 1, 0, 2'd2, 8'h55, 4'h0);
        idle(3);

        // R2 R5 R6 R7: random stream with palette rewrites in flight
        tag_px = "";
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] rv;
            rv = $urandom;
            step(rv[0] | rv[1], 8'($urandom), rv[2] & rv[3], rv[4] & rv[5],
                 rv[6] & rv[7], 2'($urandom), (rv[8] ? 8'($urandom % 8) : 8'($urandom)),
                 4'($urandom));
        end
        idle(4);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule